// File: doc/BRIEF.md
# Adaptive Luma Level Expander

This block stretches the dark and bright ends of a 10-bit luma stream according to what the previous field actually contained. While a field streams through, it records the largest and smallest valid luma sample. It also records the running sum and count of those samples. When the next field-start marker arrives, these figures are frozen into shadow registers. The shadow values then set the shape of a piecewise-linear transfer curve for every sample of the new field.

Two knee registers split the luma range into three zones. Samples between the knees are passed through untouched. Below the lower knee the distance to the knee is multiplied by a black-side gain. Above the upper knee the distance is multiplied by a white-side gain. A black-side gain rises when the previous field's darkest sample sat well above zero. A white-side gain rises when its brightest sample sat well below full scale. Each strength register scales how quickly its gain rises.

The average level of the previous field is compared against a threshold. When the field is judged bright, the extra black-side gain is halved. This avoids crushing shadows in bright scenes. A single enable bit turns the remapping off. The frozen statistics are visible on read-only outputs. Chroma is not handled here.

Top module: `lvlx_top`

## Requirements
- R1: After reset, y_out is 0, y_out_vld is 0, stat_hi is 1023, stat_lo is 0 and stat_bright is 0. With these reset statistics both gains equal exactly 1.0, so every sample maps to itself.
- R2: Every sample presented with y_vld high appears on y_out with y_out_vld high on the next clock. y_out_vld is low one clock after a cycle with y_vld low.
- R3: With en low, y_out equals the sample presented one clock earlier.
- R4: With en high, a sample with knee_lo <= y <= knee_hi leaves unchanged, knee bounds included.
- R5: On a cycle with fld_start high, the maximum and minimum of the valid samples seen since the previous fld_start move to stat_hi and stat_lo, visible one clock later. A valid sample on the fld_start cycle itself counts toward the new field.
- R6: A fld_start that closes a field with no valid samples leaves stat_hi, stat_lo and stat_bright unchanged.
- R7: stat_bright is set from the closed field as (sum of samples) > apl_limit * (sample count). This is the average level compared against apl_limit, with the apl_limit value taken on the fld_start cycle.
- R8: With en high and y < knee_lo, the output is knee_lo - t, where t = ((knee_lo - y) * gb) >> 4. Here gb = 16 + bb and bb = min(16, (stat_lo * blk_str) >> 6).
- R9: With en high and y > knee_hi (and not below knee_lo), the output is knee_hi + t, where t = ((y - knee_hi) * gw) >> 4. Here gw = 16 + min(16, ((1023 - stat_hi) * wht_str) >> 6).
- R10: The black side clips to 0 when t >= knee_lo, and the white side clips to 1023 when the sum exceeds 1023.
- R11: When stat_bright is 1, the black boost bb is halved (bb >> 1) before it is added to 16. The white gain is unaffected.
- R12: The curve applied to a sample arriving on the fld_start cycle already uses the statistics of the field that this fld_start closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Remapping enable; low passes luma through |
| y_in | input | 10 | Luma sample |
| y_vld | input | 1 | y_in holds a valid sample |
| fld_start | input | 1 | First cycle of a new field |
| knee_lo | input | 10 | Black-side knee |
| knee_hi | input | 10 | White-side knee |
| blk_str | input | 4 | Black-side strength |
| wht_str | input | 4 | White-side strength |
| apl_limit | input | 10 | Average-level threshold for bright scenes |
| y_out | output | 10 | Remapped luma |
| y_out_vld | output | 1 | y_out holds a valid sample |
| stat_hi | output | 10 | Frozen maximum of previous field |
| stat_lo | output | 10 | Frozen minimum of previous field |
| stat_bright | output | 1 | Frozen bright-scene flag |

## Verification
The bench aims at the field boundary. One case presents a sample on the same cycle as fld_start. A design that latched its statistics one cycle late would map that sample with stale gains, and it would also count the sample into the field that just closed. An empty field is closed on purpose; a design that latched blindly would load the empty-accumulator values of 0 and 1023 and swing both gains. Inputs are chosen so that both clip limits are hit. The bright-scene test checks that only the black gain is halved: halving the whole gain, or touching the white side, gives a visibly different output.

// File: rtl/lvlx_pkg.sv
package lvlx_pkg;
    localparam int DW   = 10;
    localparam int CW   = 20;
    localparam int SW   = DW + CW;
    localparam int FRAC = 4;
    localparam int GW   = FRAC + 2;
    localparam int STRW = 4;
    localparam int STRSH = 6;
    localparam logic [DW-1:0] YMAX = '1;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic [SW-1:0] sum;
        logic [CW-1:0] cnt;
    } acc_t;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic          bright;
    } shadow_t;
endpackage

// File: rtl/lvlx_stats.sv
module lvlx_stats
    import lvlx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] y_in,
    input  logic          y_vld,
    input  logic          fld_start,
    input  logic [DW-1:0] apl_limit,
    output shadow_t       shd_d,
    output shadow_t       shd_q
);
    localparam acc_t FRESH = '{hi: '0, lo: YMAX, sum: '0, cnt: '0};
    localparam shadow_t SHD_RST = '{hi: YMAX, lo: '0, bright: 1'b0};

    acc_t acc_d, acc_q;
    acc_t base;
    logic [SW-1:0] lim_scaled;

    always_comb begin
        shd_d      = shd_q;
        lim_scaled = SW'(apl_limit) * SW'(acc_q.cnt);
        if (fld_start && acc_q.cnt != '0) begin
            shd_d.hi     = acc_q.hi;
            shd_d.lo     = acc_q.lo;
            shd_d.bright = acc_q.sum > lim_scaled;
        end
        base = fld_start ? FRESH : acc_q;
        if (y_vld) begin
            if (y_in > base.hi) base.hi = y_in;
            if (y_in < base.lo) base.lo = y_in;
            if (base.cnt != '1) begin
                base.sum = base.sum + SW'(y_in);
                base.cnt = base.cnt + 1'b1;
            end
        end
        acc_d = base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= FRESH;
            shd_q <= SHD_RST;
        end else begin
            acc_q <= acc_d;
            shd_q <= shd_d;
        end
    end

    // R5
    peak_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shd_q.lo <= shd_q.hi);

    // R6
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_start && acc_q.cnt == '0) |=> $stable(shd_q));
endmodule

// File: rtl/lvlx_gain.sv
module lvlx_gain
    import lvlx_pkg::*;
(
    input  shadow_t         shd,
    input  logic [STRW-1:0] blk_str,
    input  logic [STRW-1:0] wht_str,
    output logic [GW-1:0]   gain_b,
    output logic [GW-1:0]   gain_w
);
    localparam int PW = DW + STRW;
    localparam logic [PW-1:0] CAP = PW'(1 << FRAC);

    logic [PW-1:0] raw_b, raw_w, bb, bw;
    logic [DW-1:0] head;

    always_comb begin
        head  = YMAX - shd.hi;
        raw_b = (PW'(shd.lo) * PW'(blk_str)) >> STRSH;
        raw_w = (PW'(head) * PW'(wht_str)) >> STRSH;
        bb    = (raw_b > CAP) ? CAP : raw_b;
        bw    = (raw_w > CAP) ? CAP : raw_w;
        if (shd.bright) bb = bb >> 1;
        gain_b = GW'(CAP) + GW'(bb);
        gain_w = GW'(CAP) + GW'(bw);
    end
endmodule

// File: rtl/lvlx_curve.sv
module lvlx_curve
    import lvlx_pkg::*;
(
    input  logic          en,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] knee_lo,
    input  logic [DW-1:0] knee_hi,
    input  logic [GW-1:0] gain_b,
    input  logic [GW-1:0] gain_w,
    output logic [DW-1:0] y_map
);
    localparam int MW = DW + GW;
    localparam int TW = MW - FRAC;

    logic [MW-1:0] prod;
    logic [TW-1:0] t;
    logic [TW:0]   s;

    always_comb begin
        y_map = y_in;
        prod  = '0;
        t     = '0;
        s     = '0;
        if (en && y_in < knee_lo) begin
            prod = MW'(knee_lo - y_in) * MW'(gain_b);
            t    = TW'(prod >> FRAC);
            y_map = (t >= TW'(knee_lo)) ? '0 : DW'(TW'(knee_lo) - t);
        end else if (en && y_in > knee_hi) begin
            prod = MW'(y_in - knee_hi) * MW'(gain_w);
            t    = TW'(prod >> FRAC);
            s    = (TW+1)'(knee_hi) + (TW+1)'(t);
            y_map = (s > (TW+1)'(YMAX)) ? YMAX : DW'(s);
        end
    end
endmodule

// File: rtl/lvlx_top.sv
module lvlx_top
    import lvlx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DW-1:0]   y_in,
    input  logic            y_vld,
    input  logic            fld_start,
    input  logic [DW-1:0]   knee_lo,
    input  logic [DW-1:0]   knee_hi,
    input  logic [STRW-1:0] blk_str,
    input  logic [STRW-1:0] wht_str,
    input  logic [DW-1:0]   apl_limit,
    output logic [DW-1:0]   y_out,
    output logic            y_out_vld,
    output logic [DW-1:0]   stat_hi,
    output logic [DW-1:0]   stat_lo,
    output logic            stat_bright
);
    typedef struct packed {
        logic [DW-1:0] y;
        logic          vld;
    } out_t;

    shadow_t shd_d, shd_q;
    logic [GW-1:0] gain_b, gain_w;
    logic [DW-1:0] y_map;
    out_t o_d, o_q;

    lvlx_stats u_stats (
        .clk(clk), .rst_n(rst_n), .y_in(y_in), .y_vld(y_vld),
        .fld_start(fld_start), .apl_limit(apl_limit),
        .shd_d(shd_d), .shd_q(shd_q)
    );

    lvlx_gain u_gain (
        .shd(shd_d), .blk_str(blk_str), .wht_str(wht_str),
        .gain_b(gain_b), .gain_w(gain_w)
    );

    lvlx_curve u_curve (
        .en(en), .y_in(y_in), .knee_lo(knee_lo), .knee_hi(knee_hi),
        .gain_b(gain_b), .gain_w(gain_w), .y_map(y_map)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = y_vld;
        if (y_vld) o_d.y = y_map;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign y_out       = o_q.y;
    assign y_out_vld   = o_q.vld;
    assign stat_hi     = shd_q.hi;
    assign stat_lo     = shd_q.lo;
    assign stat_bright = shd_q.bright;

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_vld |=> y_out_vld);
    // R2
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !y_vld |=> !y_out_vld);
    // R3
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_vld && !en) |=> (y_out == $past(y_in)));
    // R4
    mid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_vld && en && y_in >= knee_lo && y_in <= knee_hi) |=> (y_out == $past(y_in)));
    // R8
    black_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_vld && en && y_in < knee_lo) |=> (y_out <= $past(knee_lo)));
    // R9
    white_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_vld && en && y_in >= knee_lo && y_in > knee_hi) |=> (y_out >= $past(knee_hi)));
endmodule

// File: tb/lvlx_top_test.sv
module lvlx_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [9:0] y_in = '0;
    logic y_vld = 1'b0;
    logic fld_start = 1'b0;
    logic [9:0] knee_lo = 10'd256;
    logic [9:0] knee_hi = 10'd768;
    logic [3:0] blk_str = 4'd8;
    logic [3:0] wht_str = 4'd8;
    logic [9:0] apl_limit = 10'd800;
    logic [9:0] y_out, stat_hi, stat_lo;
    logic y_out_vld, stat_bright;

    int checks = 0;
    int errors = 0;

    int m_hi = 0, m_lo = 1023, m_sum = 0, m_cnt = 0;
    int s_hi = 1023, s_lo = 0, s_br = 0;

    always #4 clk = ~clk;

    lvlx_top uut (
        .clk(clk), .rst_n(rst_n), .en(en), .y_in(y_in), .y_vld(y_vld),
        .fld_start(fld_start), .knee_lo(knee_lo), .knee_hi(knee_hi),
        .blk_str(blk_str), .wht_str(wht_str), .apl_limit(apl_limit),
        .y_out(y_out), .y_out_vld(y_out_vld), .stat_hi(stat_hi),
        .stat_lo(stat_lo), .stat_bright(stat_bright)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(input int y);
        int bb, bw, gb, gw, t, s;
        if (!en) return y;
        bb = (s_lo * blk_str) >> 6;  if (bb > 16) bb = 16;
        if (s_br != 0) bb = bb >> 1;
        bw = ((1023 - s_hi) * wht_str) >> 6; if (bw > 16) bw = 16;
        gb = 16 + bb; gw = 16 + bw;
        if (y < knee_lo) begin
            t = ((knee_lo - y) * gb) >> 4;
            return (t >= knee_lo) ? 0 : knee_lo - t;
        end else if (y > knee_hi) begin
            t = ((y - knee_hi) * gw) >> 4;
            s = knee_hi + t;
            return (s > 1023) ? 1023 : s;
        end
        return y;
    endfunction

    function automatic void model_close();
        if (m_cnt != 0) begin
            s_hi = m_hi; s_lo = m_lo;
            s_br = (m_sum > apl_limit * m_cnt) ? 1 : 0;
        end
        m_hi = 0; m_lo = 1023; m_sum = 0; m_cnt = 0;
    endfunction

    task automatic send(input int y, input bit fs, input string req);
        int exp;
        if (fs) model_close();
        exp = model(y);
        if (y > m_hi) m_hi = y;
        if (y < m_lo) m_lo = y;
        m_sum += y; m_cnt++;
        y_in = 10'(y); y_vld = 1'b1; fld_start = fs;
        @(negedge clk);
        y_vld = 1'b0; fld_start = 1'b0;
        chk({req, " y_out"}, y_out, exp);
        chk({req, " vld"}, y_out_vld, 1);
    endtask

    task automatic new_field(input string req);
        model_close();
        fld_start = 1'b1;
        @(negedge clk);
        fld_start = 1'b0;
        chk({req, " stat_hi"}, stat_hi, s_hi);
        chk({req, " stat_lo"}, stat_lo, s_lo);
        chk({req, " stat_bright"}, stat_bright, s_br);
    endtask

    task automatic t_reset();
        chk("R1 y_out", y_out, 0);
        chk("R1 vld", y_out_vld, 0);
        chk("R1 stat_hi", stat_hi, 1023);
        chk("R1 stat_lo", stat_lo, 0);
        chk("R1 bright", stat_bright, 0);
        en = 1'b1;
        send(40, 0, "R1 identity low");
        send(1000, 0, "R1 identity high");
        send(500, 0, "R1 identity mid");
        @(negedge clk);
        chk("R2 vld drop", y_out_vld, 0);
    endtask

    task automatic t_stats();
        new_field("R5 latch");
        chk("R7 not bright", stat_bright, 0);
        send(256, 0, "R4 knee_lo bound");
        send(768, 0, "R4 knee_hi bound");
        send(600, 0, "R4 mid");
        send(200, 0, "R8 black stretch");
        send(900, 0, "R9 white stretch");
        send(0, 0, "R10 clip 0");
        send(1023, 0, "R10 clip 1023");
    endtask

    task automatic t_bypass();
        en = 1'b0;
        send(100, 0, "R3 bypass low");
        send(1000, 0, "R3 bypass high");
        en = 1'b1;
    endtask

    task automatic t_empty();
        new_field("R5 second field");
        new_field("R6 empty field");
        chk("R6 hi held", stat_hi, 1023);
    endtask

    task automatic t_bright();
        send(300, 0, "R8 fill");
        send(400, 0, "R8 fill");
        apl_limit = 10'd100;
        new_field("R7 bright set");
        chk("R11 bright flag", stat_bright, 1);
        send(100, 0, "R11 halved black boost");
        send(900, 0, "R11 white unaffected");
        apl_limit = 10'd1000;
    endtask

    task automatic t_coincide();
        send(120, 1, "R12 sample on field start");
        chk("R5 stat_lo after coincident", stat_lo, s_lo);
        chk("R7 cleared", stat_bright, 0);
        send(150, 0, "R12 second sample");
        new_field("R5 coincident counted");
        chk("R5 min counted", stat_lo, 120);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stats();
        t_bypass();
        t_empty();
        t_bright();
        t_coincide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule